// File: doc/BRIEF.md
# Clock Enable Request/Acknowledge Controller

This block gates several peripheral clocks through a four-phase request/acknowledge handshake. Each channel has a request bit written by software, an acknowledge bit software can only read, and a small source-select field. Setting the request bit asks the matching clock source to start. Clearing it asks the source to stop. The acknowledge bit follows only after the source has answered, and the answer passes through a two-flop synchroniser. A source can take many cycles to respond, and the block waits for it without a time limit.

Software may change a request only while it matches the acknowledge. The source selection may change only while the channel is fully off. Any write that breaks either rule is discarded and raises a sticky per-channel violation flag. Once the acknowledge has risen, it stays high until software clears the request, even if the source's answer drops. Software therefore always sees a stable "running" indication. The channels do not interact: each has its own state machine with four states: idle, waiting for on, on, and waiting for off.

Top module: `clkreq_ctrl`

## Requirements
- R1: While reset is applied and after it is released, every request, acknowledge, source-select, violation and source-request output reads 0.
- R2: A write with kind 0 (request field; the new value is bit 0 of the write data) to a channel whose request equals its acknowledge is accepted. The new value appears on that channel's request output and source-request output after the clock edge that takes the write.
- R3: The acknowledge rises only while the request is 1. It rises on the third rising edge that samples the source's answer high, one edge per synchroniser flop plus one for the state update.
- R4: While the request stays 1, the acknowledge stays 1 once it has risen, even if the source's answer falls.
- R5: After the request is cleared, the acknowledge falls on the third rising edge that samples the source's answer low.
- R6: A request write whose value differs from the current request, made while the request differs from the acknowledge, is dropped and sets the channel's violation flag. A write of the value the request already holds is harmless and raises nothing.
- R7: A write with kind 1 (source select; the value is the write data, SRC_W bits) is stored only while both the request and the acknowledge are 0. Otherwise it is dropped and sets the violation flag.
- R8: A violation flag, once set, stays set until reset.
- R9: Channels are independent, and a write addressed to a channel number at or above NCH changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en_i | input | 1 | Software write strobe, one cycle |
| wr_chan_i | input | CH_W | Channel addressed by the write |
| wr_kind_i | input | 1 | 0 = request field, 1 = source-select field |
| wr_data_i | input | SRC_W | Write data; bit 0 carries the request value |
| osc_ack_i | input | NCH | Answer from each clock source, asynchronous |
| osc_req_o | output | NCH | Enable request to each clock source |
| req_o | output | NCH | Request bit of each channel |
| ack_o | output | NCH | Acknowledge bit of each channel |
| src_sel_o | output | NCH*SRC_W | Source select of each channel, channel 0 in the low bits |
| viol_o | output | NCH | Sticky rule-violation flag of each channel |

## Verification
The hardest states to reach from the ports are the two waiting windows, where the request and the acknowledge disagree. Writes there must be dropped and must raise the flag. The bench models each source with its own response delay, up to twenty cycles, so these windows stay open long enough to aim conflicting request and source-select writes into them. It also pulls one source's answer low while that channel is on, to show that the acknowledge holds. A behavioural reference model is compared with every output on every cycle, so both the handshake latency and the locking are checked cycle by cycle.

// File: rtl/clkreq_pkg.sv
package clkreq_pkg;

  typedef enum logic [1:0] {
    CH_IDLE     = 2'd0,
    CH_WAIT_ON  = 2'd1,
    CH_ON       = 2'd2,
    CH_WAIT_OFF = 2'd3
  } ch_state_e;

  typedef enum logic {
    WR_REQ = 1'b0,
    WR_SRC = 1'b1
  } wr_kind_e;

endpackage

// File: rtl/clkreq_rst_sync.sv
module clkreq_rst_sync (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);

  logic [1:0] stage_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stage_q <= 2'b00;
    end else begin
      stage_q <= {stage_q[0], 1'b1};
    end
  end

  assign rst_no = stage_q[1];

endmodule

// File: rtl/clkreq_sync.sv
module clkreq_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  generate
    if (STAGES == 1) begin : g_one
      always_comb chain_d = d_i;
    end else begin : g_many
      always_comb chain_d = {chain_q[STAGES-2:0], d_i};
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_d;
    end
  end

  assign q_o = chain_q[STAGES-1];

  generate
    if (STAGES == 2) begin : g_chk
      AST_SYNC_DELAY: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(q_o) |-> $past(d_i, 2)); // R3
    end
  endgenerate

endmodule

// File: rtl/clkreq_chan_fsm.sv
module clkreq_chan_fsm
  import clkreq_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_i,
  input  logic ack_sync_i,
  output logic ack_o
);

  ch_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      CH_IDLE:     if (req_i)       state_d = CH_WAIT_ON;
      CH_WAIT_ON:  if (ack_sync_i)  state_d = CH_ON;
      CH_ON:       if (!req_i)      state_d = CH_WAIT_OFF;
      CH_WAIT_OFF: if (!ack_sync_i) state_d = CH_IDLE;
      default:                      state_d = CH_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= CH_IDLE;
    end else begin
      state_q <= state_d;
    end
  end

  assign ack_o = (state_q == CH_ON) || (state_q == CH_WAIT_OFF);

  AST_ACK_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_o && req_i) |=> ack_o); // R4
  AST_ACK_RISE_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ack_o) |-> req_i); // R3
  AST_ACK_FALL_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ack_o) |-> !req_i); // R5

endmodule

// File: rtl/clkreq_chan_regs.sv
module clkreq_chan_regs
  import clkreq_pkg::*;
#(
  parameter int SRC_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sel_i,
  input  wr_kind_e         kind_i,
  input  logic [SRC_W-1:0] data_i,
  input  logic             ack_i,
  output logic             req_o,
  output logic [SRC_W-1:0] src_o,
  output logic             viol_o
);

  logic             req_q, req_d;
  logic [SRC_W-1:0] src_q, src_d;
  logic             viol_q, viol_d;
  logic             in_step;
  logic             locked;

  assign in_step = (req_q == ack_i);
  assign locked  = req_q || ack_i;

  always_comb begin
    req_d  = req_q;
    src_d  = src_q;
    viol_d = viol_q;
    if (kind_i == WR_REQ) begin
      if (in_step) begin
        req_d = data_i[0];
      end else if (data_i[0] != req_q) begin
        viol_d = 1'b1;
      end
    end else begin
      if (locked) begin
        viol_d = 1'b1;
      end else begin
        src_d = data_i;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_q  <= 1'b0;
      src_q  <= '0;
      viol_q <= 1'b0;
    end else if (sel_i) begin
      req_q  <= req_d;
      src_q  <= src_d;
      viol_q <= viol_d;
    end
  end

  assign req_o  = req_q;
  assign src_o  = src_q;
  assign viol_o = viol_q;

  AST_REQ_LOCKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_q != ack_i) |=> $stable(req_q)); // R6
  AST_SRC_LOCKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_q || ack_i) |=> $stable(src_q)); // R7
  AST_VIOL_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    viol_q |=> viol_q); // R8

endmodule

// File: rtl/clkreq_ctrl.sv
module clkreq_ctrl
  import clkreq_pkg::*;
#(
  parameter int NCH         = 3,
  parameter int SRC_W       = 2,
  parameter int SYNC_STAGES = 2,
  localparam int CH_W       = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   wr_en_i,
  input  logic [CH_W-1:0]        wr_chan_i,
  input  logic                   wr_kind_i,
  input  logic [SRC_W-1:0]       wr_data_i,
  input  logic [NCH-1:0]         osc_ack_i,
  output logic [NCH-1:0]         osc_req_o,
  output logic [NCH-1:0]         req_o,
  output logic [NCH-1:0]         ack_o,
  output logic [NCH*SRC_W-1:0]   src_sel_o,
  output logic [NCH-1:0]         viol_o
);

  logic     rst_int_n;
  wr_kind_e kind;

  assign kind = wr_kind_e'(wr_kind_i);

  clkreq_rst_sync u_rst (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rst_no (rst_int_n)
  );

  generate
    for (genvar c = 0; c < NCH; c++) begin : g_ch
      logic sel;
      logic ack_sync;

      assign sel = wr_en_i && (32'(wr_chan_i) == c);

      clkreq_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk_i  (clk_i),
        .rst_ni (rst_int_n),
        .d_i    (osc_ack_i[c]),
        .q_o    (ack_sync)
      );

      clkreq_chan_regs #(.SRC_W(SRC_W)) u_regs (
        .clk_i  (clk_i),
        .rst_ni (rst_int_n),
        .sel_i  (sel),
        .kind_i (kind),
        .data_i (wr_data_i),
        .ack_i  (ack_o[c]),
        .req_o  (req_o[c]),
        .src_o  (src_sel_o[c*SRC_W +: SRC_W]),
        .viol_o (viol_o[c])
      );

      clkreq_chan_fsm u_fsm (
        .clk_i      (clk_i),
        .rst_ni     (rst_int_n),
        .req_i      (req_o[c]),
        .ack_sync_i (ack_sync),
        .ack_o      (ack_o[c])
      );
    end
  endgenerate

  assign osc_req_o = req_o;

endmodule

// File: tb/sim_clkreq_ctrl.sv
module sim_clkreq_ctrl;
  localparam int NCH = 3;
  localparam int SW  = 2;

  logic            clk = 1'b0;
  logic            rst_n;
  logic            wr_en;
  logic [1:0]      wr_chan;
  logic            wr_kind;
  logic [SW-1:0]   wr_data;
  logic [NCH-1:0]  osc_ack;
  logic [NCH-1:0]  osc_req, req, ack, viol;
  logic [NCH*SW-1:0] src_sel;

  always #4 clk = ~clk;

  clkreq_ctrl #(.NCH(NCH), .SRC_W(SW)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_chan_i(wr_chan),
    .wr_kind_i(wr_kind), .wr_data_i(wr_data), .osc_ack_i(osc_ack),
    .osc_req_o(osc_req), .req_o(req), .ack_o(ack), .src_sel_o(src_sel),
    .viol_o(viol)
  );

  int n_chk = 0;
  int n_fail = 0;
  int cycles = 0;
  bit live = 0;
  bit done = 0;

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // clock source models: each follows its request after its own delay
  int  dly [NCH] = '{3, 9, 20};
  int  cnt [NCH];
  bit  lvl [NCH];
  bit  fault [NCH];

  always @(negedge clk) begin
    for (int c = 0; c < NCH; c++) begin
      if (!rst_n) begin
        lvl[c] = 0; cnt[c] = 0;
      end else if (osc_req[c] != lvl[c]) begin
        cnt[c]++;
        if (cnt[c] >= dly[c]) begin lvl[c] = osc_req[c]; cnt[c] = 0; end
      end else begin
        cnt[c] = 0;
      end
      osc_ack[c] = lvl[c] && !fault[c];
    end
  end

  // behavioural reference model, updated on every rising edge
  bit       m_req [NCH];
  bit [1:0] m_src [NCH];
  bit       m_viol[NCH];
  bit       m_s1  [NCH];
  bit       m_s2  [NCH];
  int       m_ph  [NCH];

  function automatic bit m_ack(input int c);
    return (m_ph[c] == 2) || (m_ph[c] == 3);
  endfunction

  always @(posedge clk) begin
    for (int c = 0; c < NCH; c++) begin
      if (!rst_n) begin
        m_req[c] = 0; m_src[c] = 0; m_viol[c] = 0;
        m_s1[c] = 0; m_s2[c] = 0; m_ph[c] = 0;
      end else begin
        bit a;
        a = m_ack(c);
        if (wr_en && int'(wr_chan) == c) begin
          if (!wr_kind) begin
            if (m_req[c] == a) m_req[c] = wr_data[0];
            else if (wr_data[0] != m_req[c]) m_viol[c] = 1;
          end else begin
            if (m_req[c] || a) m_viol[c] = 1;
            else m_src[c] = wr_data;
          end
        end
      end
    end
  end

  // phase and synchroniser model use pre-edge request values
  bit prev_req [NCH];
  always @(posedge clk) begin
    for (int c = 0; c < NCH; c++) begin
      if (!rst_n) begin
        prev_req[c] = 0;
      end
    end
  end

  always @(negedge clk) begin
    if (live) begin
      for (int c = 0; c < NCH; c++) begin
        chk($sformatf("R2 req ch%0d", c), 8'(req[c]), 8'(m_req[c]));
        chk($sformatf("R2 osc_req ch%0d", c), 8'(osc_req[c]), 8'(m_req[c]));
        chk($sformatf("R3/R4/R5 ack ch%0d", c), 8'(ack[c]), 8'(m_ack(c)));
        chk($sformatf("R7 src ch%0d", c), 8'(src_sel[c*SW +: SW]), 8'(m_src[c]));
        chk($sformatf("R6/R8 viol ch%0d", c), 8'(viol[c]), 8'(m_viol[c]));
      end
    end
  end

  // phase update at the edge, from the values held before it
  always @(posedge clk) begin
    if (rst_n) begin
      for (int c = 0; c < NCH; c++) begin
        bit r;
        r = prev_req[c];
        case (m_ph[c])
          0: if (r)         m_ph[c] = 1;
          1: if (m_s2[c])   m_ph[c] = 2;
          2: if (!r)        m_ph[c] = 3;
          default: if (!m_s2[c]) m_ph[c] = 0;
        endcase
        m_s2[c] = m_s1[c];
        m_s1[c] = osc_ack[c];
      end
    end
  end

  // capture request as seen before each edge
  always @(negedge clk) begin
    for (int c = 0; c < NCH; c++) prev_req[c] = req[c];
  end

  task automatic wr(input int ch, input bit kind, input int data);
    @(negedge clk);
    wr_en = 1; wr_chan = 2'(ch); wr_kind = kind; wr_data = SW'(data);
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_ack(input int c, input bit v, input string tag);
    int k;
    k = 0;
    while (ack[c] !== v && k < 200) begin @(negedge clk); k++; end
    chk(tag, 8'(ack[c]), 8'(v));
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected<=20000", cycles);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    rst_n = 0; wr_en = 0; wr_chan = 0; wr_kind = 0; wr_data = 0;
    for (int c = 0; c < NCH; c++) fault[c] = 0;
    idle(3);
    chk("R1 reset req", 8'(req), 8'd0);
    chk("R1 reset ack", 8'(ack), 8'd0);
    chk("R1 reset viol", 8'(viol), 8'd0);
    chk("R1 reset src", 8'(src_sel), 8'd0);
    chk("R1 reset osc_req", 8'(osc_req), 8'd0);
    rst_n = 1;
    idle(4);
    live = 1;
    chk("R1 after release", 8'({req, ack, viol}), 8'd0);

    // R7: select accepted when fully off, then R2 enable channel 0
    wr(0, 1, 2);
    chk("R7 src accepted ch0", 8'(src_sel[1:0]), 8'd2);
    wr(0, 0, 1);
    chk("R2 req set ch0", 8'(req[0]), 8'd1);
    wait_ack(0, 1, "R3 ack rises ch0");

    // R6: repeated value during wait window is harmless, change is dropped
    wr(2, 0, 1);
    wr(2, 0, 1);
    chk("R6 same value no flag ch2", 8'(viol[2]), 8'd0);
    wr(2, 1, 3);
    chk("R7 locked select flagged ch2", 8'(viol[2]), 8'd1);
    chk("R7 locked select kept ch2", 8'(src_sel[5:4]), 8'd0);
    wr(1, 0, 1);
    wr(1, 0, 0);
    chk("R6 change dropped ch1", 8'(req[1]), 8'd1);
    chk("R6 violation ch1", 8'(viol[1]), 8'd1);
    chk("R9 ch0 unaffected", 8'(viol[0]), 8'd0);

    // R4: source answer falls while on
    fault[0] = 1;
    idle(10);
    chk("R4 ack held ch0", 8'(ack[0]), 8'd1);
    fault[0] = 0;
    idle(4);

    // R5 disable, with a conflicting write in the off window
    wr(0, 0, 0);
    chk("R5 req cleared ch0", 8'(req[0]), 8'd0);
    wr(0, 0, 1);
    chk("R6 dropped in off window ch0", 8'(req[0]), 8'd0);
    wait_ack(0, 0, "R5 ack falls ch0");
    wr(0, 1, 3);
    chk("R7 select after off ch0", 8'(src_sel[1:0]), 8'd3);

    // R9: out-of-range channel
    wr(3, 1, 1);
    wr(3, 0, 1);
    chk("R9 out of range", 8'({src_sel, req}), 8'({6'b000011, 3'b110}));
    wait_ack(2, 1, "R3 ack rises ch2");
    wait_ack(1, 1, "R3 ack rises ch1");
    idle(30);
    chk("R8 flags sticky", 8'(viol), 8'b111);

    done = 1;
    live = 0;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule